// File: doc/BRIEF.md
# GPIO Edge Interrupt and Wakeup Unit

This unit watches the already-synchronized levels of a port of GPIO pins, finds rising and falling transitions on each pin and records them as pending interrupt bits. Each direction has its own enable mask, so a pin can interrupt on rising edges, falling edges or both. A second, fully independent pair of direction masks selects which transitions count as wakeup events; these latch into their own per-pin wake status.

Pending bits stay set until firmware writes ones to a clear address. The OR of all pending bits drives a single registered interrupt line toward the parent controller. The OR of all wake status bits drives a registered wakeup line. Firmware usually services the port by reading the pending word, handling and clearing the lowest set bit, and repeating until the word is zero. Only edge triggering exists.

Registers sit on a simple word-addressed bus with a 3-bit address. Writes take effect on the clock edge where they are presented. Read data is registered and appears one cycle after the request.

Top module: `gpio_edge_wake_unit`

## Requirements
- R1: A 0-to-1 change of a pin's level, seen between two consecutive clock edges, sets that pin's pending bit (register address 4) at the edge where the new level is first sampled, if the pin's bit in the rising interrupt mask (address 0) is 1.
- R2: A 1-to-0 change of a pin's level sets that pin's pending bit at the same edge, if the pin's bit in the falling interrupt mask (address 1) is 1.
- R3: An edge whose matching interrupt mask bit is 0 leaves the pending bit unchanged.
- R4: With both interrupt mask bits of a pin set, both edge directions set the pending bit.
- R5: The wake masks (rising at address 2, falling at address 3) set bits in the wake status (address 6) and never in the pending word. The interrupt masks never set wake status bits.
- R6: Writing a word to address 5 clears each pending bit where that word has a 1 and leaves the bits where it has a 0. Repeatedly clearing the lowest pending bit empties the word in ascending bit order.
- R7: If an enabled edge and a clear of the same pending bit land on the same clock edge, the bit stays set.
- R8: The interrupt output is high one cycle after the pending word holds any 1, and low one cycle after the pending word becomes zero.
- R9: The wakeup output is high one cycle after the wake status holds any 1. Writing ones to address 7 clears the matching wake status bits, and the output falls one cycle later.
- R10: A synchronous reset clears all four masks, both status words, both outputs and the read data.
- R11: The mask registers read back the value written. Read data appears on the cycle after a read request and holds until the next read. Addresses 5 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NPINS | Synchronized pin levels |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Registered read data |
| irq_o | output | 1 | Combined interrupt to parent controller |
| wake_o | output | 1 | Combined wakeup request |

## Verification
The bench aims at the collision of a fresh edge with a clear of the same bit. A design where the clear wins would lose that interrupt and read back zero. It checks that the wake and interrupt mask pairs do not leak into each other's status word, which would raise spurious wakeups or interrupts. It checks that an edge on a disabled direction leaves the pending word alone, so a design that ignores edge polarity would show extra bits. It drives a lowest-first service loop over several pins and measures the one-cycle lag of both outputs, so partial clearing or an output taken from the wrong status word would show up as a wrong bit order or a line that stays high.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [2:0] {
    REG_RISE_IRQ  = 3'd0,
    REG_FALL_IRQ  = 3'd1,
    REG_RISE_WAKE = 3'd2,
    REG_FALL_WAKE = 3'd3,
    REG_PEND      = 3'd4,
    REG_PEND_CLR  = 3'd5,
    REG_WAKE      = 3'd6,
    REG_WAKE_CLR  = 3'd7
  } reg_sel_e;
  localparam int ADDR_W = 3;
endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] level_i,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  always_comb begin
    rise_o = level_i & ~prev_q;
    fall_o = ~level_i & prev_q;
  end
endmodule

// File: rtl/gpio_w1c_status.sv
module gpio_w1c_status #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] set_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] q_o,
  output logic             any_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o   <= '0;
      any_o <= 1'b0;
    end else begin
      q_o   <= (q_o & ~clr_i) | set_i;
      any_o <= |q_o;
    end
  end

  // R6
  clr_only_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R8
  any_low_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o == '0) |=> !any_o);

  // R8
  any_high_chk: assert property (@(posedge clk) disable iff (rst)
    (q_o != '0) |=> any_o);
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  input  logic [NPINS-1:0]  pend_i,
  input  logic [NPINS-1:0]  wake_i,
  output logic [NPINS-1:0]  rise_irq_m,
  output logic [NPINS-1:0]  fall_irq_m,
  output logic [NPINS-1:0]  rise_wake_m,
  output logic [NPINS-1:0]  fall_wake_m,
  output logic [NPINS-1:0]  pend_clr,
  output logic [NPINS-1:0]  wake_clr,
  output logic [NPINS-1:0]  rdata
);
  logic     wr_hit;
  logic     rd_hit;
  reg_sel_e sel;

  always_comb begin
    sel      = reg_sel_e'(bus_addr);
    wr_hit   = bus_en & bus_wr;
    rd_hit   = bus_en & ~bus_wr;
    pend_clr = (wr_hit && sel == REG_PEND_CLR) ? bus_wdata : '0;
    wake_clr = (wr_hit && sel == REG_WAKE_CLR) ? bus_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_irq_m  <= '0;
      fall_irq_m  <= '0;
      rise_wake_m <= '0;
      fall_wake_m <= '0;
    end else if (wr_hit) begin
      case (sel)
        REG_RISE_IRQ:  rise_irq_m  <= bus_wdata;
        REG_FALL_IRQ:  fall_irq_m  <= bus_wdata;
        REG_RISE_WAKE: rise_wake_m <= bus_wdata;
        REG_FALL_WAKE: fall_wake_m <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      case (sel)
        REG_RISE_IRQ:  rdata <= rise_irq_m;
        REG_FALL_IRQ:  rdata <= fall_irq_m;
        REG_RISE_WAKE: rdata <= rise_wake_m;
        REG_FALL_WAKE: rdata <= fall_wake_m;
        REG_PEND:      rdata <= pend_i;
        REG_WAKE:      rdata <= wake_i;
        default:       rdata <= '0;
      endcase
    end
  end

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(rdata));

  // R11
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && (sel == REG_PEND_CLR || sel == REG_WAKE_CLR)) |=> (rdata == '0));
endmodule

// File: rtl/gpio_edge_wake_unit.sv
module gpio_edge_wake_unit
  import gpio_edge_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_level,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] rise, fall;
  logic [NPINS-1:0] rise_irq_m, fall_irq_m, rise_wake_m, fall_wake_m;
  logic [NPINS-1:0] pend_clr, wake_clr;
  logic [NPINS-1:0] pend_q, wake_q;
  logic [NPINS-1:0] pend_set, wake_set;

  gpio_edge_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .level_i(pin_level), .rise_o(rise), .fall_o(fall)
  );

  gpio_edge_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend_i(pend_q), .wake_i(wake_q),
    .rise_irq_m(rise_irq_m), .fall_irq_m(fall_irq_m),
    .rise_wake_m(rise_wake_m), .fall_wake_m(fall_wake_m),
    .pend_clr(pend_clr), .wake_clr(wake_clr), .rdata(bus_rdata)
  );

  always_comb begin
    pend_set = (rise & rise_irq_m)  | (fall & fall_irq_m);
    wake_set = (rise & rise_wake_m) | (fall & fall_wake_m);
  end

  gpio_w1c_status #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst(rst), .set_i(pend_set), .clr_i(pend_clr),
    .q_o(pend_q), .any_o(irq_o)
  );

  gpio_w1c_status #(.NPINS(NPINS)) u_wake (
    .clk(clk), .rst(rst), .set_i(wake_set), .clr_i(wake_clr),
    .q_o(wake_q), .any_o(wake_o)
  );

  // R3
  no_unmasked_set_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) &
               ~(($past(rise) & $past(rise_irq_m)) | ($past(fall) & $past(fall_irq_m)))) == '0));

  // R5
  wake_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((wake_q & ~$past(wake_q) &
               ~(($past(rise) & $past(rise_wake_m)) | ($past(fall) & $past(fall_wake_m)))) == '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !wake_o && pend_q == '0 && wake_q == '0 && bus_rdata == '0));
endmodule

// File: tb/tb_gpio_edge_wake_unit.sv
module tb_gpio_edge_wake_unit;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pins = '0;
  logic         bus_en = 1'b0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic         irq_o, wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_edge_wake_unit #(.NPINS(N)) dut (
    .clk(clk), .rst(rst), .pin_level(pins),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive(input logic [N-1:0] v);
    @(negedge clk);
    pins = v;
    @(negedge clk);
  endtask

  task automatic clear_masks();
    for (int a = 0; a < 4; a++) wr(3'(a), '0);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    check("R10 irq after reset", {31'd0, irq_o}, '0);
    check("R10 wake after reset", {31'd0, wake_o}, '0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R10 register zero after reset", d, '0);
    end
  endtask

  task automatic t_readback();
    logic [N-1:0] d;
    wr(3'd0, 32'hA5A5_0001);
    wr(3'd1, 32'h5A5A_0002);
    wr(3'd2, 32'h0F0F_0004);
    wr(3'd3, 32'hF0F0_0008);
    rd(3'd0, d); check("R11 rise irq mask readback", d, 32'hA5A5_0001);
    rd(3'd1, d); check("R11 fall irq mask readback", d, 32'h5A5A_0002);
    rd(3'd2, d); check("R11 rise wake mask readback", d, 32'h0F0F_0004);
    rd(3'd3, d); check("R11 fall wake mask readback", d, 32'hF0F0_0008);
    rd(3'd5, d); check("R11 pend clear reads zero", d, '0);
    rd(3'd7, d); check("R11 wake clear reads zero", d, '0);
    cyc(); cyc();
    check("R11 rdata holds without read", bus_rdata, '0);
    clear_masks();
  endtask

  task automatic t_masked_off();
    logic [N-1:0] d;
    drive(32'hFFFF_FFFF);
    drive(32'h0000_0000);
    rd(3'd4, d); check("R3 no pending with masks off", d, '0);
    check("R3 irq low with masks off", {31'd0, irq_o}, '0);
  endtask

  task automatic t_rise();
    logic [N-1:0] d;
    wr(3'd0, 32'h0000_0011);
    drive(32'h0000_0011);
    rd(3'd4, d); check("R1 rising edges pending", d, 32'h0000_0011);
    check("R8 irq high", {31'd0, irq_o}, 32'd1);
    drive(32'h0000_0000);
    rd(3'd4, d); check("R3 falling edge ignored with fall mask off", d, 32'h0000_0011);
    wr(3'd5, 32'h0000_0001);
    rd(3'd4, d); check("R6 partial clear", d, 32'h0000_0010);
    wr(3'd5, 32'h0000_0010);
    check("R8 irq lags clear by one cycle", {31'd0, irq_o}, 32'd1);
    cyc();
    check("R8 irq low after pending empty", {31'd0, irq_o}, '0);
    clear_masks();
  endtask

  task automatic t_fall();
    logic [N-1:0] d;
    wr(3'd1, 32'h8000_0000);
    drive(32'h8000_0000);
    rd(3'd4, d); check("R2 rising edge ignored with only fall mask", d, '0);
    drive(32'h0000_0000);
    rd(3'd4, d); check("R2 falling edge pending", d, 32'h8000_0000);
    wr(3'd5, 32'hFFFF_FFFF);
    clear_masks();
  endtask

  task automatic t_both();
    logic [N-1:0] d;
    wr(3'd0, 32'h0000_0020);
    wr(3'd1, 32'h0000_0020);
    drive(32'h0000_0020);
    rd(3'd4, d); check("R4 both masks, rising", d, 32'h0000_0020);
    wr(3'd5, 32'h0000_0020);
    rd(3'd4, d); check("R4 cleared between edges", d, '0);
    drive(32'h0000_0000);
    rd(3'd4, d); check("R4 both masks, falling", d, 32'h0000_0020);
    wr(3'd5, 32'hFFFF_FFFF);
    clear_masks();
    cyc();
  endtask

  task automatic t_wake();
    logic [N-1:0] d;
    wr(3'd2, 32'h0000_0080);
    wr(3'd3, 32'h0000_0100);
    wr(3'd0, 32'h0000_0200);
    drive(32'h0000_0380);
    rd(3'd6, d); check("R5 wake status from wake rise mask only", d, 32'h0000_0080);
    rd(3'd4, d); check("R5 pending from irq mask only", d, 32'h0000_0200);
    check("R9 wake output high", {31'd0, wake_o}, 32'd1);
    drive(32'h0000_0000);
    rd(3'd6, d); check("R5 wake fall mask sets wake status", d, 32'h0000_0180);
    wr(3'd7, 32'h0000_0180);
    rd(3'd6, d); check("R9 wake clear", d, '0);
    check("R9 wake output low", {31'd0, wake_o}, '0);
    wr(3'd5, 32'hFFFF_FFFF);
    clear_masks();
  endtask

  task automatic t_collide();
    logic [N-1:0] d;
    wr(3'd0, 32'h0000_0008);
    drive(32'h0000_0008);
    drive(32'h0000_0000);
    @(negedge clk);
    pins = 32'h0000_0008;
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h0000_0008;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
    rd(3'd4, d); check("R7 new edge beats same-cycle clear", d, 32'h0000_0008);
    wr(3'd5, 32'hFFFF_FFFF);
    drive(32'h0000_0000);
    clear_masks();
  endtask

  task automatic t_service();
    logic [N-1:0] d;
    int order [4];
    int got;
    int idx;
    order[0] = 2; order[1] = 9; order[2] = 17; order[3] = 30;
    wr(3'd0, 32'hFFFF_FFFF);
    drive(32'h4002_0204);
    got = 0;
    rd(3'd4, d);
    check("R6 service start word", d, 32'h4002_0204);
    while (d != '0 && got < 8) begin
      idx = 0;
      for (int b = N - 1; b >= 0; b--) if (d[b]) idx = b;
      if (got < 4) check("R6 lowest-first order", 32'(idx), 32'(order[got]));
      got++;
      wr(3'd5, 32'd1 << idx);
      rd(3'd4, d);
    end
    check("R6 service count", 32'(got), 32'd4);
    cyc();
    check("R8 irq low after service", {31'd0, irq_o}, '0);
    clear_masks();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_masked_off();
    t_rise();
    t_fall();
    t_both();
    t_wake();
    t_collide();
    t_service();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule